// File: doc/BRIEF.md
# Burst Line Fetch Controller

This block sits on the host side of an asynchronous read-only memory that supports a fast sequential mode. The host presents an aligned line address and a width select, then pulses a start strobe. The controller drives the chip-enable and output-enable strobes low together and holds the upper address bits for the whole line. It then walks the low address bits upward from zero. The first beat is sampled only after the full random-access delay. Each following beat is sampled after the shorter sequential-access delay.

In 16-bit mode a line is four words, stepped on the two word-select bits. In 8-bit mode a line is eight bytes, stepped on those two bits plus the byte-select line. Every captured beat leaves on a one-cycle valid pulse, and the final beat also carries a last flag. All delays are given in picoseconds and turned into whole clock counts, rounded up. After the strobes are released, the block stays busy until the data bus has had time to float, so no other agent drives the bus too early.

Top module: `burst_line_fetch`

## Requirements
- R1: While reset is held and after its release, busy_o is 0, rom_ce_n_o and rom_oe_n_o are 1, and beat_valid_o and beat_last_o are 0.
- R2: A start_i seen while busy_o is 0 is accepted. On the next cycle busy_o is 1, rom_ce_n_o and rom_oe_n_o are 0, rom_addr_o[ADDR_W-1:2] equals line_addr_i, and rom_addr_o[1:0] and rom_lsb_o are 0.
- R3: The first beat is sampled FIRST_CYC clocks after the strobes fall, where FIRST_CYC = max(ceil(T_ACC_PS/CLK_PS), ceil(T_OE_PS/CLK_PS)). With the default parameters this is 13.
- R4: Every later beat is sampled BURST_CYC = ceil(T_BURST_PS/CLK_PS) clocks after the preceding low-address step, which is 7 with the defaults. The low bits step on the same edge that captures a beat.
- R5: With byte_mode_i = 0, a line has four beats. rom_addr_o[1:0] takes 0,1,2,3 in turn, rom_lsb_o stays 0, and beat_data_o is the full 16-bit bus.
- R6: With byte_mode_i = 1, a line has eight beats. {rom_addr_o[1:0], rom_lsb_o} takes 0..7 in turn, beat_data_o[7:0] is rom_data_i[7:0], and beat_data_o[15:8] is 0.
- R7: beat_valid_o pulses for exactly one cycle per captured beat. beat_last_o is 1 only together with the final beat's valid.
- R8: rom_addr_o[ADDR_W-1:2] stays constant while the strobes are low.
- R9: The strobes rise on the edge that captures the final beat. busy_o then stays 1 for FLOAT_CYC = ceil(T_FLOAT_PS/CLK_PS) more clocks (5 with the defaults) and falls.
- R10: A start_i seen while busy_o is 1 is ignored. This holds whether the strobes are low or the bus is still floating. The current line's addresses and beats are unaffected, and no new line follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to fetch one line |
| line_addr_i | input | ADDR_W-2 | Line address (upper word-address bits) |
| byte_mode_i | input | 1 | 1 = eight 8-bit beats, 0 = four 16-bit beats |
| busy_o | output | 1 | Fetch in progress or bus still floating |
| rom_addr_o | output | ADDR_W | Word address to the memory |
| rom_lsb_o | output | 1 | Byte-select address line (8-bit mode only) |
| rom_ce_n_o | output | 1 | Chip enable, active low |
| rom_oe_n_o | output | 1 | Output enable, active low |
| rom_data_i | input | DATA_W | Memory data bus |
| beat_valid_o | output | 1 | One captured beat is on beat_data_o |
| beat_last_o | output | 1 | Current beat is the last of the line |
| beat_data_o | output | DATA_W | Captured beat, zero-extended in 8-bit mode |

## Verification
The bench builds the block with its default timing: an 8 ns clock with 100, 50, 60 and 35 ns delays. That gives counts of 13, 7 and 5, far enough apart that a wait off by one clock lands a sample inside the memory model's stale window and returns a poison value. The default 18-bit address lets lines at the bottom and top of the range be fetched. It also lets a start be offered during the access phase, during the float phase, and on the first cycle after busy falls.

// File: rtl/blf_pkg.sv
// Package: shared state type and compile-time timing helpers for the
// burst line fetch controller. Assumes all times are in picoseconds.
package blf_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_FIRST = 2'd1,
        FS_NEXT  = 2'd2,
        FS_FLOAT = 2'd3
    } fetch_state_t;

    // Whole clock cycles covering a delay, rounded up.
    function automatic int ceil_cycles(input int delay_ps, input int period_ps);
        return (delay_ps + period_ps - 1) / period_ps;
    endfunction

    // Larger of two counts.
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/blf_wait_timer.sv
// Module: blf_wait_timer
// Down-counter for wait windows. Loading a value N makes expire_o high
// N-1 cycles later, so the owner acts on the N-th edge after the load.
// Assumes N >= 1. A load always overrides the running count.
module blf_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new window or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/blf_beat_seq.sv
// Module: blf_beat_seq
// Holds the line address and width mode for one fetch and walks the beat
// index up from zero. Assumes begin_i and step_i are never high together.
module blf_beat_seq #(
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              begin_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              byte_i,
    input  logic              step_i,
    output logic [LINE_W-1:0] line_o,
    output logic              byte_o,
    output logic [2:0]        idx_o,
    output logic              final_o
);
    localparam logic [2:0] LAST_WORD = 3'd3;
    localparam logic [2:0] LAST_BYTE = 3'd7;

    logic [LINE_W-1:0] line_q;
    logic              byte_q;
    logic [2:0]        idx_q;

    // Latch line and mode at the start of a fetch; advance the index per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            byte_q <= 1'b0;
            idx_q  <= '0;
        end else if (begin_i) begin
            line_q <= line_i;
            byte_q <= byte_i;
            idx_q  <= '0;
        end else if (step_i) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign line_o  = line_q;
    assign byte_o  = byte_q;
    assign idx_o   = idx_q;
    assign final_o = byte_q ? (idx_q == LAST_BYTE) : (idx_q == LAST_WORD);
endmodule

// File: rtl/blf_beat_capture.sv
// Module: blf_beat_capture
// Registers the memory bus when told to, zero-extending the low byte in
// 8-bit mode, and raises valid (and last) for exactly that one cycle.
module blf_beat_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              final_i,
    input  logic              byte_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              valid_o,
    output logic              last_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] shaped;

    // Choose the full bus or the zero-extended low half.
    always_comb begin
        if (byte_i) begin
            shaped = {{(DATA_W - HALF_W){1'b0}}, bus_i[HALF_W-1:0]};
        end else begin
            shaped = bus_i;
        end
    end

    // Capture a beat and produce the one-cycle stream flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            last_o  <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= take_i;
            last_o  <= take_i & final_i;
            if (take_i) begin
                data_o <= shaped;
            end
        end
    end
endmodule

// File: rtl/burst_line_fetch.sv
// Module: burst_line_fetch
// Host-side controller fetching one aligned line (four words or eight bytes)
// from an asynchronous memory in its sequential access mode. The first beat
// waits the random-access time (or the output-enable time, if longer). Later
// beats wait the sequential time. After release, busy holds for the bus
// float time. Assumes the memory is the only load on the strobes, and that
// data stays valid for a short hold after each address step.
module burst_line_fetch #(
    parameter int CLK_PS      = 8000,
    parameter int T_ACC_PS    = 100000,
    parameter int T_BURST_PS  = 50000,
    parameter int T_OE_PS     = 60000,
    parameter int T_FLOAT_PS  = 35000,
    parameter int ADDR_W      = 18,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-3:0] line_addr_i,
    input  logic              byte_mode_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] rom_addr_o,
    output logic              rom_lsb_o,
    output logic              rom_ce_n_o,
    output logic              rom_oe_n_o,
    input  logic [DATA_W-1:0] rom_data_i,
    output logic              beat_valid_o,
    output logic              beat_last_o,
    output logic [DATA_W-1:0] beat_data_o
);
    import blf_pkg::*;

    localparam int LINE_W    = ADDR_W - 2;
    localparam int ACC_CYC   = ceil_cycles(T_ACC_PS, CLK_PS);
    localparam int OE_CYC    = ceil_cycles(T_OE_PS, CLK_PS);
    localparam int FIRST_CYC = max_of(max_of(ACC_CYC, OE_CYC), 1);
    localparam int BURST_CYC = max_of(ceil_cycles(T_BURST_PS, CLK_PS), 1);
    localparam int FLOAT_CYC = max_of(ceil_cycles(T_FLOAT_PS, CLK_PS), 1);
    localparam int MAX_CYC   = max_of(max_of(FIRST_CYC, BURST_CYC), FLOAT_CYC);
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    fetch_state_t      state_q, state_d;
    logic              timer_load;
    logic [CNT_W-1:0]  timer_val;
    logic              timer_expire;
    logic              seq_begin, seq_step;
    logic [LINE_W-1:0] line_w;
    logic              byte_mode_w;
    logic [2:0]        idx_w;
    logic              final_w;
    logic              take_beat;
    logic              strobes_on;

    // Wait-window counter shared by all three phases.
    blf_wait_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (timer_load),
        .load_val_i (timer_val),
        .expire_o   (timer_expire)
    );

    // Line address, mode and beat index.
    blf_beat_seq #(.LINE_W(LINE_W)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .begin_i (seq_begin),
        .line_i  (line_addr_i),
        .byte_i  (byte_mode_i),
        .step_i  (seq_step),
        .line_o  (line_w),
        .byte_o  (byte_mode_w),
        .idx_o   (idx_w),
        .final_o (final_w)
    );

    // Beat register and stream flags.
    blf_beat_capture #(.DATA_W(DATA_W)) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take_beat),
        .final_i (final_w),
        .byte_i  (byte_mode_w),
        .bus_i   (rom_data_i),
        .valid_o (beat_valid_o),
        .last_o  (beat_last_o),
        .data_o  (beat_data_o)
    );

    // Phase sequencing: decide loads, captures, steps and the next phase.
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        seq_begin  = 1'b0;
        seq_step   = 1'b0;
        take_beat  = 1'b0;
        case (state_q)
            FS_IDLE: begin
                if (start_i) begin
                    seq_begin  = 1'b1;
                    timer_load = 1'b1;
                    timer_val  = CNT_W'(FIRST_CYC);
                    state_d    = FS_FIRST;
                end
            end
            FS_FIRST, FS_NEXT: begin
                if (timer_expire) begin
                    take_beat  = 1'b1;
                    timer_load = 1'b1;
                    if (final_w) begin
                        timer_val = CNT_W'(FLOAT_CYC);
                        state_d   = FS_FLOAT;
                    end else begin
                        seq_step  = 1'b1;
                        timer_val = CNT_W'(BURST_CYC);
                        state_d   = FS_NEXT;
                    end
                end
            end
            FS_FLOAT: begin
                if (timer_expire) begin
                    state_d = FS_IDLE;
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign strobes_on = (state_q == FS_FIRST) || (state_q == FS_NEXT);
    assign rom_ce_n_o = ~strobes_on;
    assign rom_oe_n_o = ~strobes_on;
    assign busy_o     = (state_q != FS_IDLE);
    assign rom_addr_o = {line_w, (byte_mode_w ? idx_w[2:1] : idx_w[1:0])};
    assign rom_lsb_o  = byte_mode_w & idx_w[0];
endmodule

// File: rtl/burst_line_fetch_chk.sv
// Module: burst_line_fetch_chk
// Property checker bound to burst_line_fetch. Observes ports plus the
// latched width mode. Drives nothing.
module burst_line_fetch_chk #(
    parameter int ADDR_W = 18,
    parameter int HI_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-3:0] line_addr_i,
    input logic              busy_o,
    input logic [ADDR_W-1:0] rom_addr_o,
    input logic              rom_lsb_o,
    input logic              rom_ce_n_o,
    input logic              beat_valid_o,
    input logic              beat_last_o,
    input logic [HI_W-1:0]   beat_hi,
    input logic              byte_mode
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !rom_ce_n_o && rom_addr_o[1:0] == 2'b00
            && !rom_lsb_o && rom_addr_o[ADDR_W-1:2] == $past(line_addr_i)));

    // R8
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n_o && $past(!rom_ce_n_o)) |-> $stable(rom_addr_o[ADDR_W-1:2]));

    // R7
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last_o |-> beat_valid_o);

    // R6
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && byte_mode) |-> (beat_hi == '0));

    // R9
    release_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_ce_n_o) |-> (busy_o && beat_last_o));

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !rom_ce_n_o && !beat_last_o) |=> busy_o);
endmodule

bind burst_line_fetch burst_line_fetch_chk #(
    .ADDR_W (ADDR_W),
    .HI_W   (DATA_W - DATA_W / 2)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .line_addr_i  (line_addr_i),
    .busy_o       (busy_o),
    .rom_addr_o   (rom_addr_o),
    .rom_lsb_o    (rom_lsb_o),
    .rom_ce_n_o   (rom_ce_n_o),
    .beat_valid_o (beat_valid_o),
    .beat_last_o  (beat_last_o),
    .beat_hi      (beat_data_o[DATA_W-1:DATA_W/2]),
    .byte_mode    (byte_mode_w)
);

// File: tb/burst_line_fetch_tb_top.sv
// Bench: behavioural memory with a stale-data window, plus a per-cycle
// reference schedule of strobes, addresses, busy and stream beats.
module burst_line_fetch_tb_top;
    localparam int T_CLK  = 8000;
    localparam int ACC_C  = (100000 + T_CLK - 1) / T_CLK;
    localparam int OE_C   = (60000 + T_CLK - 1) / T_CLK;
    localparam int FIRST  = (ACC_C > OE_C) ? ACC_C : OE_C;
    localparam int BURST  = (50000 + T_CLK - 1) / T_CLK;
    localparam int FLOATC = (35000 + T_CLK - 1) / T_CLK;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] line_addr_i = '0;
    logic        byte_mode_i = 1'b0;
    logic        busy_o;
    logic [17:0] rom_addr_o;
    logic        rom_lsb_o, rom_ce_n_o, rom_oe_n_o;
    logic [15:0] rom_data_i = 16'hBAD0;
    logic        beat_valid_o, beat_last_o;
    logic [15:0] beat_data_o;

    int cyc = 0;
    logic rst_at_edge = 1'b0;
    int n_vec = 0;
    int n_bad = 0;

    int s_edge = -1000, e1_edge = -1000, busy_end = 0;
    logic [15:0] cur_line = '0;
    logic cur_byte = 1'b0;
    int exp_cyc_q[$];
    logic [15:0] exp_dat_q[$];
    bit exp_last_q[$];

    int c0 = 0, ca = 0;
    logic prev_ce_n = 1'b1;
    logic [18:0] prev_full = '0;

    always #4ns clk = ~clk;

    burst_line_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_addr_i(line_addr_i),
        .byte_mode_i(byte_mode_i), .busy_o(busy_o), .rom_addr_o(rom_addr_o),
        .rom_lsb_o(rom_lsb_o), .rom_ce_n_o(rom_ce_n_o), .rom_oe_n_o(rom_oe_n_o),
        .rom_data_i(rom_data_i), .beat_valid_o(beat_valid_o),
        .beat_last_o(beat_last_o), .beat_data_o(beat_data_o)
    );

    function automatic logic [15:0] rom_word(input logic [17:0] a);
        return a[15:0] ^ {a[1:0], a[17:16], 12'h000} ^ 16'h5A3C;
    endfunction

    function automatic logic [7:0] rom_byte(input logic [17:0] a, input logic lsb);
        logic [15:0] w;
        w = rom_word(a);
        return lsb ? w[15:8] : w[7:0];
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        rst_at_edge <= rst_n;
    end

    // Per-cycle comparison and memory model (runs after edge cyc).
    always @(negedge clk) begin
        int k, idx;
        bit on, expv, ready;
        k = cyc;
        if (!rst_at_edge) begin
            check("R1", "busy", busy_o, 0);
            check("R1", "ce_n", rom_ce_n_o, 1);
            check("R1", "oe_n", rom_oe_n_o, 1);
            check("R1", "valid", beat_valid_o, 0);
            check("R1", "last", beat_last_o, 0);
        end else begin
            on = (k >= s_edge) && (k < e1_edge);
            check("R9", "busy", busy_o, (k >= s_edge && k < busy_end) ? 1 : 0);
            check("R2", "ce_n", rom_ce_n_o, on ? 0 : 1);
            check("R2", "oe_n", rom_oe_n_o, on ? 0 : 1);
            if (on) begin
                idx = (k < s_edge + FIRST) ? 0 : 1 + (k - s_edge - FIRST) / BURST;
                check("R8", "line", rom_addr_o[17:2], cur_line);
                if (cur_byte)
                    check("R6", "byte index", {rom_addr_o[1:0], rom_lsb_o}, idx);
                else begin
                    check("R5", "word index", rom_addr_o[1:0], idx);
                    check("R5", "lsb", rom_lsb_o, 0);
                end
            end
            expv = (exp_cyc_q.size() > 0) && (exp_cyc_q[0] == k);
            check("R3", "valid", beat_valid_o, expv ? 1 : 0);
            if (expv) begin
                check("R4", "data", beat_data_o, exp_dat_q[0]);
                check("R7", "last", beat_last_o, exp_last_q[0] ? 1 : 0);
                void'(exp_cyc_q.pop_front());
                void'(exp_dat_q.pop_front());
                void'(exp_last_q.pop_front());
            end else begin
                check("R7", "last idle", beat_last_o, 0);
            end
        end
        // Memory: data is poison until the access windows have passed.
        if (!rom_ce_n_o && !rom_oe_n_o) begin
            if (prev_ce_n) begin
                c0 = k;
                ca = k;
            end else if ({rom_addr_o, rom_lsb_o} != prev_full) begin
                ca = k;
            end
            ready = (k + 1 - c0 >= FIRST) && (k + 1 - ca >= BURST);
            if (!ready) rom_data_i = 16'hBAD0;
            else if (cur_byte) rom_data_i = {8'hC3, rom_byte(rom_addr_o, rom_lsb_o)};
            else rom_data_i = rom_word(rom_addr_o);
        end else begin
            rom_data_i = 16'hBAD0;
        end
        prev_ce_n = rom_ce_n_o;
        prev_full = {rom_addr_o, rom_lsb_o};
    end

    // Offer one start pulse and, if the block is idle, schedule the line.
    task automatic fire(input logic [15:0] line, input logic bmode);
        int nb;
        @(negedge clk); #1ns;
        start_i = 1'b1;
        line_addr_i = line;
        byte_mode_i = bmode;
        if (cyc >= busy_end) begin
            s_edge = cyc + 1;
            cur_line = line;
            cur_byte = bmode;
            nb = bmode ? 8 : 4;
            for (int i = 0; i < nb; i++) begin
                logic [17:0] a;
                exp_cyc_q.push_back(s_edge + FIRST + i * BURST);
                if (bmode) begin
                    a = {line, i[2:1]};
                    exp_dat_q.push_back({8'h00, rom_byte(a, i[0])});
                end else begin
                    a = {line, i[1:0]};
                    exp_dat_q.push_back(rom_word(a));
                end
                exp_last_q.push_back(i == nb - 1);
            end
            e1_edge = s_edge + FIRST + (nb - 1) * BURST;
            busy_end = e1_edge + FLOATC;
        end
        @(negedge clk); #1ns;
        start_i = 1'b0;
        line_addr_i = ~line;
    endtask

    task automatic wait_idle();
        while (cyc < busy_end) @(negedge clk);
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    initial begin
        // R1: start offered inside reset must be ignored
        start_i = 1'b1;
        repeat (4) @(negedge clk);
        #1ns;
        start_i = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R5: word line
        fire(16'h1234, 1'b0);
        wait_idle();
        // R6: byte line at the top of the range
        fire(16'hFFFF, 1'b1);
        // R10: start during the access phase is ignored
        fire(16'h0F0F, 1'b0);
        wait_until(e1_edge);
        // R10: start while the bus floats is ignored
        fire(16'h5555, 1'b1);
        wait_idle();
        // R2: start on the first idle cycle, line zero, byte mode
        fire(16'h0000, 1'b1);
        wait_idle();
        fire(16'hA5C3, 1'b0);
        wait_idle();
        repeat (10) @(negedge clk);
        check("R7", "leftover beats", exp_cyc_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual cycle %0d expected below 20000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule